// File: doc/BRIEF.md
# Serial-Clocked SAR Conversion Sequencer

This block is the digital core of a successive-approximation converter whose serial clock also drives the conversion. While `cs_n` is low, the block watches the serial data line for a start bit. It then collects a control word on rising serial-clock edges and opens a three-clock acquisition window. After that it runs a 12-bit or 8-bit binary search against an external trial DAC and comparator, and it shifts each decided bit out on the falling edge where that bit is resolved.

Every signal is sampled by a fast system clock `clk`. A rising or falling serial-clock edge is recognised one `clk` after it appears on `dclk`. All frame positions below are counted in serial-clock edges from the start bit, which is rising edge 1. A new control word may begin while the previous result is still being shifted out. The spacing between words depends on the resolution of the running word. Releasing `cs_n` abandons everything in flight.

Top module: `serial_sar_seq`

## Requirements
- R1: `dout_oe` and `busy_oe` equal the inverse of `cs_n`. After reset, `busy` and `track` are low.
- R2: Zeros on `din` before a start bit are ignored, and all serial activity is ignored while `cs_n` is high. The control word is 8 bits, sent MSB first on rising edges. Bit 7 is the start bit (1). Bits 6:4 are the address. Bit 3 selects resolution (0 = 12-bit, 1 = 8-bit). Bit 2 is the reference select. Bits 1:0 are the power bits.
- R3: `dout` is low from the start of a frame until falling edge 9, so the first nine bits read on rising edges 1 to 9 are zero.
- R4: `track` rises on falling edge 5 and falls on falling edge 8.
- R5: `busy` rises on falling edge 8 and clears on falling edge 9. On falling edge 8 the power bits are copied to `pwr_mode` and bit 2 to `ref_single`.
- R6: In 12-bit mode the result leaves MSB first on falling edges 9 to 20, and `dout` is zero afterwards. The result is the largest code for which the comparator reports the input at or above it.
- R7: In 8-bit mode the eight upper result bits leave on falling edges 9 to 16, and `dout` is zero from falling edge 17.
- R8: On falling edge 8 `dac_code` becomes 0x800. At each step the bit under trial is kept when `cmp_hi` is 1 (input at or above `dac_code`) and cleared otherwise, and the next lower bit is set. The final `dac_code` equals the result, left-justified in 8-bit mode.
- R9: In 12-bit mode a 1 on `din` at rising edges 9 to 15 is not a start bit. A start bit at rising edge 16 begins a new word while the old result is still being shifted out.
- R10: In 8-bit mode a 1 at rising edges 9 to 11 is not a start bit, and a start bit at rising edge 12 is accepted.
- R11: Raising `cs_n` aborts any conversion. After re-selection `dout` stays low and `busy` stays low until a new word arrives, and that new word converts normally.
- R12: Address 000 bypasses the search. The result is 0x800 (0x80 in 8-bit mode), `cmp_hi` is ignored and `dac_code` stays 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and tri-states |
| dclk | input | 1 | Serial and conversion clock |
| din | input | 1 | Serial control data |
| cmp_hi | input | 1 | Comparator: analog input at or above `dac_code` |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| busy | output | 1 | One-clock conversion-start flag |
| busy_oe | output | 1 | Output enable for `busy` |
| dac_code | output | 12 | Trial code for the external DAC |
| track | output | 1 | Acquisition window active |
| pwr_mode | output | 2 | Power bits latched at hold |
| ref_single | output | 1 | Reference select bit latched at hold |

## Verification
A wrong frame count in the control receiver shows up within one serial clock. It moves `track` or `busy` off their expected falling edges, and it shifts the whole result on `dout` by whole bit positions. A corrupted trial register or step index shows as a wrong data bit on the very falling edge where that bit is decided, and again later as a wrong final `dac_code`. Broken start blanking first appears as a mangled earlier result in an overlapped stream. Missing abort handling appears as stray ones on `dout` straight after re-selection.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
   localparam int WORD_LEN = 8;

   typedef struct packed {
      logic       start;
      logic [2:0] addr;
      logic       res8;
      logic       ref_se;
      logic [1:0] pwr;
   } ctl_word_t;
endpackage

// File: rtl/sarseq_edge.sv
module sarseq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic dclk,
   output logic rise,
   output logic fall
);
   logic dclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dclk_q <= 1'b0;
      else        dclk_q <= dclk;
   end

   assign rise = dclk & ~dclk_q;
   assign fall = ~dclk & dclk_q;
endmodule

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
   import sarseq_pkg::*;
#(
   parameter int       BLANK_HI  = 7,
   parameter int       BLANK_LO  = 3,
   parameter int       ACQ_START = 5,
   parameter int       ACQ_LEN   = 3,
   parameter bit       ID_EN     = 1'b1,
   parameter bit [2:0] ID_ADDR   = 3'b000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       din,
   input  logic       rise,
   input  logic       fall,
   output logic       hold,
   output logic       res8,
   output logic       ident,
   output logic       track,
   output logic       busy,
   output logic [1:0] pwr_mode,
   output logic       ref_single
);
   localparam int HOLD_EDGE = ACQ_START + ACQ_LEN;
   localparam int PER_HI    = WORD_LEN + BLANK_HI;
   localparam int PER_LO    = WORD_LEN + BLANK_LO;
   localparam int CNT_W     = $clog2(PER_HI + 1) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0]    cnt;
   logic [WORD_LEN-1:0] shreg;
   logic [CNT_W-1:0]    period;
   logic                accept;
   ctl_word_t           cur;

   assign cur    = ctl_word_t'(shreg);
   assign period = cur.res8 ? CNT_W'(PER_LO) : CNT_W'(PER_HI);
   assign accept = rise && din && !cs_n && ((cnt == '0) || (cnt >= period));
   assign hold   = fall && !cs_n && cur.start && (cnt == CNT_W'(HOLD_EDGE));
   assign res8   = cur.res8;

   generate
      if (ID_EN) begin : g_ident
         assign ident = (cur.addr == ID_ADDR);
      end else begin : g_noident
         assign ident = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
         track <= 1'b0;
         busy  <= 1'b0;
      end else if (cs_n) begin
         cnt   <= '0;
         shreg <= '0;
         track <= 1'b0;
         busy  <= 1'b0;
      end else begin
         if (accept) begin
            cnt   <= CNT_W'(1);
            shreg <= WORD_LEN'(1);
         end else if (rise && (cnt != '0)) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt < CNT_W'(WORD_LEN)) shreg <= {shreg[WORD_LEN-2:0], din};
         end
         if (fall) begin
            busy <= hold;
            if (cnt == CNT_W'(ACQ_START)) track <= 1'b1;
            if (hold)                     track <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_mode   <= '0;
         ref_single <= 1'b0;
      end else if (hold) begin
         pwr_mode   <= cur.pwr;
         ref_single <= cur.ref_se;
      end
   end

   // R4
   track_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(track) |-> (cnt == CNT_W'(ACQ_START)));
   // R5
   busy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fall) |=> !busy);
   // R4
   track_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      track |-> !busy);
   // R1
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> ((cnt == '0) && !busy && !track));
endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
   parameter int RES_HI = 12,
   parameter int RES_LO = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              fall,
   input  logic              hold,
   input  logic              res8,
   input  logic              ident,
   input  logic              cmp_hi,
   output logic [RES_HI-1:0] code,
   output logic              dout
);
   localparam int STEP_W = $clog2(RES_HI);
   localparam logic [RES_HI-1:0] MID = RES_HI'(1) << (RES_HI - 1);
   localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(RES_HI - 1);
   localparam logic [STEP_W-1:0] LAST_LO  = STEP_W'(RES_HI - RES_LO);

   logic [STEP_W-1:0] step, last_q;
   logic              conv_on, ident_q, bit_val;
   logic [RES_HI-1:0] code_nx;

   always_comb begin
      bit_val = ident_q ? code[step] : cmp_hi;
      code_nx = code;
      if (!ident_q) begin
         code_nx[step] = bit_val;
         if (step != last_q) code_nx[step - 1'b1] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code    <= '0;
         step    <= '0;
         last_q  <= '0;
         conv_on <= 1'b0;
         ident_q <= 1'b0;
         dout    <= 1'b0;
      end else if (cs_n) begin
         conv_on <= 1'b0;
         dout    <= 1'b0;
      end else if (hold) begin
         code    <= MID;
         step    <= TOP_STEP;
         last_q  <= res8 ? LAST_LO : '0;
         conv_on <= 1'b1;
         ident_q <= ident;
         dout    <= 1'b0;
      end else if (fall) begin
         if (conv_on) begin
            code <= code_nx;
            dout <= bit_val;
            if (step == last_q) conv_on <= 1'b0;
            else                step    <= step - 1'b1;
         end else begin
            dout <= 1'b0;
         end
      end
   end

   // R8
   midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (conv_on && (code == MID)));
   // R11
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!conv_on && !dout));
   // R3
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && fall && !hold && !conv_on) |=> !dout);
   // R7
   step_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_on |-> (step >= last_q));
   // R12
   ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_on && ident_q) |-> (code == MID));
endmodule

// File: rtl/serial_sar_seq.sv
module serial_sar_seq
   import sarseq_pkg::*;
#(
   parameter int       RES_HI    = 12,
   parameter int       RES_LO    = 8,
   parameter int       BLANK_HI  = 7,
   parameter int       BLANK_LO  = 3,
   parameter int       ACQ_START = 5,
   parameter int       ACQ_LEN   = 3,
   parameter bit       ID_EN     = 1'b1,
   parameter bit [2:0] ID_ADDR   = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              dclk,
   input  logic              din,
   input  logic              cmp_hi,
   output logic              dout,
   output logic              dout_oe,
   output logic              busy,
   output logic              busy_oe,
   output logic [RES_HI-1:0] dac_code,
   output logic              track,
   output logic [1:0]        pwr_mode,
   output logic              ref_single
);
   generate
      if (RES_LO < 1 || RES_LO >= RES_HI) begin : g_bad_res
         $error("resolution parameters out of range");
      end
      if (ACQ_START + ACQ_LEN != WORD_LEN) begin : g_bad_acq
         $error("hold must fall on the last control clock");
      end
      if (WORD_LEN + BLANK_HI <= RES_HI || WORD_LEN + BLANK_LO <= RES_LO) begin : g_bad_blank
         $error("blanking too short for overlapped words");
      end
   endgenerate

   logic rise, fall, hold, res8, ident;

   sarseq_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .dclk (dclk),
      .rise (rise),
      .fall (fall)
   );

   sarseq_ctrl #(
      .BLANK_HI (BLANK_HI),
      .BLANK_LO (BLANK_LO),
      .ACQ_START(ACQ_START),
      .ACQ_LEN  (ACQ_LEN),
      .ID_EN    (ID_EN),
      .ID_ADDR  (ID_ADDR)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .din       (din),
      .rise      (rise),
      .fall      (fall),
      .hold      (hold),
      .res8      (res8),
      .ident     (ident),
      .track     (track),
      .busy      (busy),
      .pwr_mode  (pwr_mode),
      .ref_single(ref_single)
   );

   sarseq_sar #(
      .RES_HI(RES_HI),
      .RES_LO(RES_LO)
   ) u_sar (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .fall  (fall),
      .hold  (hold),
      .res8  (res8),
      .ident (ident),
      .cmp_hi(cmp_hi),
      .code  (dac_code),
      .dout  (dout)
   );

   assign dout_oe = ~cs_n;
   assign busy_oe = ~cs_n;
endmodule

// File: tb/serial_sar_seq_tb_top.sv
module serial_sar_seq_tb_top;
   localparam int H = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        dclk = 1'b0;
   logic        din = 1'b0;
   logic        cmp_hi;
   logic        dout, dout_oe, busy, busy_oe, track, ref_single;
   logic [11:0] dac_code;
   logic [1:0]  pwr_mode;
   logic [11:0] vin = 12'h000;

   int nchk = 0;
   int nerr = 0;

   logic        rd [0:63];
   logic        bz [0:63];
   logic        tk [0:63];
   logic [11:0] dc [0:63];

   always #2.5 clk = ~clk;

   assign cmp_hi = (vin >= dac_code);

   serial_sar_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .din(din),
      .cmp_hi(cmp_hi), .dout(dout), .dout_oe(dout_oe), .busy(busy),
      .busy_oe(busy_oe), .dac_code(dac_code), .track(track),
      .pwr_mode(pwr_mode), .ref_single(ref_single)
   );

   // {addr[2:0], res8, pwr[1:0], vin[11:0], expected[11:0]}
   localparam logic [29:0] VEC [7] = '{
      {3'b001, 1'b0, 2'b11, 12'hABC, 12'hABC},
      {3'b101, 1'b0, 2'b01, 12'h000, 12'h000},
      {3'b011, 1'b0, 2'b10, 12'hFFF, 12'hFFF},
      {3'b001, 1'b1, 2'b00, 12'hABC, 12'h0AB},
      {3'b011, 1'b1, 2'b11, 12'h07F, 12'h007},
      {3'b000, 1'b0, 2'b01, 12'h123, 12'h800},
      {3'b000, 1'b1, 2'b10, 12'h555, 12'h080}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic frame(input logic [63:0] bits, input int n);
      for (int i = 0; i < n; i++) begin
         din = bits[n-1-i];
         tick(H);
         rd[i] = dout; bz[i] = busy; tk[i] = track; dc[i] = dac_code;
         dclk = 1'b1;
         tick(H);
         dclk = 1'b0;
      end
      din = 1'b0;
      tick(H);
   endtask

   function automatic int getbits(input int from, input int nb);
      int v = 0;
      for (int k = 0; k < nb; k++) v = (v << 1) | int'(rd[from+k]);
      return v;
   endfunction

   function automatic int busycount(input int n);
      int c = 0;
      for (int k = 0; k < n; k++) c += int'(bz[k]);
      return c;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      logic [7:0] wa, wb;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      chk("R1 reset dout_oe", int'(dout_oe), 0);
      chk("R1 reset busy_oe", int'(busy_oe), 0);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset track", int'(track), 0);
      cs_n = 1'b0;
      tick(1);
      chk("R1 selected dout_oe", int'(dout_oe), 1);
      chk("R1 selected busy_oe", int'(busy_oe), 1);

      // R2: serial activity while deselected is ignored
      cs_n = 1'b1;
      frame({64{1'b1}}, 8);
      cs_n = 1'b0;
      tick(2);
      frame(64'h0, 24);
      chk("R2 no start while deselected busy", busycount(24), 0);
      chk("R2 no start while deselected dout", getbits(0, 24), 0);
      cs_n = 1'b1;
      tick(4);

      for (int v = 0; v < 7; v++) begin
         logic [29:0] e;
         logic [7:0]  w;
         int L, nb, n, expf;
         string tg;
         e = VEC[v];
         L = v % 3;
         nb = e[26] ? 8 : 12;
         n = 24 + L;
         w = {1'b1, e[29:27], e[26], 1'b1, e[25:24]};
         vin = e[23:12];
         tg = (e[29:27] == 3'b000) ? "R12 identity data" : (e[26] ? "R7 8-bit data" : "R6 12-bit data");
         cs_n = 1'b0;
         tick(2);
         frame({40'h0, w, 16'h0}, n);
         chk("R3 leading zeros", getbits(L, 9), 0);
         chk(tg, getbits(L + 9, nb), int'(e[11:0]));
         chk("R6 R7 trailing zeros", getbits(L + 9 + nb, 15 - nb), 0);
         chk("R2 R5 busy window", {bz[L+7], bz[L+8], bz[L+9]}, 3'b010);
         chk("R4 track window", {tk[L+4], tk[L+5], tk[L+7], tk[L+8]}, 4'b0110);
         chk("R5 pwr latch", int'(pwr_mode), int'(e[25:24]));
         chk("R5 ref latch", int'(ref_single), 1);
         chk("R8 midscale at hold", int'(dc[L+8]), 12'h800);
         expf = (e[29:27] == 3'b000) ? 12'h800 : (e[26] ? int'(e[11:0]) << 4 : int'(e[11:0]));
         chk("R8 final trial code", int'(dac_code), expf);
         cs_n = 1'b1;
         tick(4);
      end

      // R9: 12-bit overlap, ones blanked at rising 9..15, next word at 16
      vin = 12'h3C5;
      wa = {1'b1, 3'b001, 1'b0, 1'b1, 2'b11};
      wb = {1'b1, 3'b011, 1'b1, 1'b0, 2'b01};
      cs_n = 1'b0;
      tick(2);
      frame({25'h0, wa, 7'h7F, wb, 16'h0}, 39);
      chk("R9 first result", getbits(9, 12), 12'h3C5);
      chk("R9 gap zeros", getbits(21, 3), 0);
      chk("R9 second busy", int'(bz[23]), 1);
      chk("R9 second result", getbits(24, 8), 8'h3C);
      chk("R9 second pwr", int'(pwr_mode), 1);
      chk("R9 second ref", int'(ref_single), 0);
      cs_n = 1'b1;
      tick(4);

      // R10: 8-bit overlap, ones blanked at rising 9..11, next word at 12
      vin = 12'h9E7;
      wa = {1'b1, 3'b101, 1'b1, 1'b1, 2'b00};
      wb = {1'b1, 3'b001, 1'b0, 1'b1, 2'b10};
      cs_n = 1'b0;
      tick(2);
      frame({29'h0, wa, 3'b111, wb, 16'h0}, 35);
      chk("R10 first result", getbits(9, 8), 8'h9E);
      chk("R10 second busy", int'(bz[19]), 1);
      chk("R10 second result", getbits(20, 12), 12'h9E7);
      chk("R10 trailing zeros", getbits(32, 3), 0);
      chk("R10 second pwr", int'(pwr_mode), 2);
      cs_n = 1'b1;
      tick(4);

      // R11: abort mid-conversion
      vin = 12'hFFF;
      wa = {1'b1, 3'b001, 1'b0, 1'b1, 2'b00};
      cs_n = 1'b0;
      tick(2);
      frame({50'h0, wa, 6'h0}, 14);
      cs_n = 1'b1;
      tick(1);
      chk("R11 abort dout_oe", int'(dout_oe), 0);
      chk("R11 abort busy_oe", int'(busy_oe), 0);
      tick(3);
      cs_n = 1'b0;
      tick(2);
      frame(64'h0, 6);
      chk("R11 no stale data", getbits(0, 6), 0);
      chk("R11 no stale busy", busycount(6), 0);
      cs_n = 1'b1;
      tick(4);
      vin = 12'h5A5;
      cs_n = 1'b0;
      tick(2);
      frame({40'h0, wa, 16'h0}, 24);
      chk("R11 recovery result", getbits(9, 12), 12'h5A5);
      cs_n = 1'b1;
      tick(4);

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule